// File: doc/BRIEF.md
# ADC conversion sequencer with register front end

This block is the digital half of an eight-input, 12-bit successive-approximation converter attached to a byte-wide register bus. Software reaches it through four byte registers. Two read-only registers hold the result. A control register holds the input select, the pin-mode field, the busy flag and the start bit. A clock register picks the conversion clock rate. The analog multiplexer, the trial DAC, the comparator and the pad circuits lie outside the block. It drives them through `chan_sel`, `dac_code`, `sample_en` and `pin_dig_en`, and it reads one comparator bit back on `cmp_in`.

A conversion needs a complete start pulse: software writes the start bit to 1 and then to 0. The rising write sets the busy flag. The falling write begins a sample phase of one conversion-clock period. Twelve trial steps follow, most significant bit first. When the last bit is decided, both result registers load at once and the busy flag drops. The register bus is a plain register interface with no data stream. A write always completes in its own cycle, and read data is combinational from the address, so there is no back-pressure.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `sample_en` is 0, `dac_code` is 0 and `pin_dig_en` is all ones.
- R2: Register addresses are 0x26 for control, 0x27 for clock and 0x24/0x25 for result low/high. Control bits 2:0 are the input select and bits 5:3 are the pin field, and both read back as written. Bit 6 reads the busy flag and bit 7 reads the stored start bit. The clock register reads back bits 7 and 1:0 and reads 0 elsewhere.
- R3: Writes to 0x24 and 0x25 leave both result registers unchanged.
- R4: A control write that takes the start bit from 0 to 1 sets the busy flag, readable the cycle after the write. No sampling starts while the start bit stays 1.
- R5: A control write that takes the start bit from 1 to 0, with the sequence armed, starts the conversion. `sample_en` is high for one conversion-clock period. The busy flag reads 0 exactly 13 conversion-clock periods after that write.
- R6: The trial code begins at 0x800 and is decided from MSB to LSB. A bit is kept when `cmp_in` is 1, meaning the input is at or above the trial code. The result equals the input code.
- R7: The result is left-justified. 0x25 holds result bits 11:4. Bits 7:4 of 0x24 hold result bits 3:0, and bits 3:0 of 0x24 read 0.
- R8: Clock register bits 1:0 set the conversion-clock period in system clocks: code 0 gives 2, code 1 gives 8, and codes 2 and 3 give 32. The code is taken when the conversion starts.
- R9: Bit 7 of the clock register has no effect on timing or result.
- R10: A 0-to-1 start write during a conversion aborts it. The busy flag stays 1, sampling stops, the result registers keep their old value, and the next falling write starts a fresh conversion.
- R11: A control write that changes the pin field to a nonzero value sets the busy flag to 1. The flag then stays 1 until a full start pulse and conversion complete. A write that sets the field to 0 does not change the flag.
- R12: For pin field value n, pins 0..n-1 are analog, and n=7 makes all eight pins analog. `pin_dig_en[i]` is 0 for an analog pin and 1 otherwise.
- R13: `chan_sel` equals control bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data decoded from bus_addr |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| dac_code | output | 12 | Current trial code for the DAC |
| sample_en | output | 1 | High during the sample phase |
| chan_sel | output | 3 | Analog input select |
| pin_dig_en | output | 8 | Per-pin digital I/O and pull-up enable |

## Verification
If the sequencer state is wrong, the busy flag at bit 6 of 0x26 shows it first. The flag drops on the wrong cycle, drops too early after an abort, or never drops, so a timing fault appears within 13 conversion-clock periods of the falling start write. A fault in the trial register or bit index shows up as a result different from the input code at 0x24/0x25 once the flag falls. A fault in the divider-select latch shows up as a count of cycles that does not fit the chosen code. A decode fault shows at once in pin_dig_en and chan_sel after the control write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [7:0] ADDR_RES_LO = 8'h24;
  localparam logic [7:0] ADDR_RES_HI = 8'h25;
  localparam logic [7:0] ADDR_CTRL   = 8'h26;
  localparam logic [7:0] ADDR_CLK    = 8'h27;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNINIT,
    ST_ARMED,
    ST_SAMPLE,
    ST_CONV
  } seq_state_t;
endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
  parameter int DIV_FAST = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int CNT_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_sel;

  always_comb begin
    unique case (sel)
      2'd0:    lim_sel = CNT_W'(DIV_FAST - 1);
      2'd1:    lim_sel = CNT_W'(DIV_MID - 1);
      default: lim_sel = CNT_W'(DIV_SLOW - 1);
    endcase
  end

  // the period is frozen while a conversion runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(DIV_FAST - 1);
    end else if (!active) begin
      cnt_q <= '0;
      lim_q <= lim_sel;
    end else if (cnt_q == lim_q) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = active && (cnt_q == lim_q);
endmodule

// File: rtl/adc_sar_fsm.sv
module adc_sar_fsm
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rise,
  input  logic             start_fall,
  input  logic             cfg_dirty,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             busy,
  output logic             active,
  output logic             sample_en,
  output logic             done,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);
  localparam int BIDX_W = $clog2(RES_W);

  seq_state_t        state_q;
  logic [RES_W-1:0]  sar_q;
  logic [RES_W-1:0]  sar_nxt;
  logic [BIDX_W-1:0] bidx_q;
  logic [BIDX_W-1:0] bidx_m1;
  logic              last_bit;

  assign bidx_m1  = bidx_q - 1'b1;
  assign last_bit = (bidx_q == '0);

  always_comb begin
    sar_nxt = sar_q;
    sar_nxt[bidx_q] = cmp_in;
    if (!last_bit) sar_nxt[bidx_m1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      bidx_q  <= '0;
      result  <= '0;
    end else if (start_rise) begin
      state_q <= ST_ARMED;
      sar_q   <= '0;
      bidx_q  <= '0;
    end else if (cfg_dirty) begin
      state_q <= ST_UNINIT;
      sar_q   <= '0;
      bidx_q  <= '0;
    end else begin
      unique case (state_q)
        ST_ARMED: if (start_fall) state_q <= ST_SAMPLE;
        ST_SAMPLE: if (tick) begin
          sar_q   <= {1'b1, {(RES_W-1){1'b0}}};
          bidx_q  <= BIDX_W'(RES_W - 1);
          state_q <= ST_CONV;
        end
        ST_CONV: if (tick) begin
          if (last_bit) begin
            result  <= sar_nxt;
            sar_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            sar_q  <= sar_nxt;
            bidx_q <= bidx_m1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign active    = (state_q == ST_SAMPLE) || (state_q == ST_CONV);
  assign sample_en = (state_q == ST_SAMPLE);
  assign dac_code  = sar_q;
  assign done      = (state_q == ST_CONV) && tick && last_bit && !start_rise && !cfg_dirty;
endmodule

// File: rtl/adc_regs.sv
module adc_regs
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CH_W  = 3,
  parameter int CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             busy,
  input  logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  chan,
  output logic [CFG_W-1:0] cfg,
  output logic [1:0]       clk_sel,
  output logic             start_rise,
  output logic             start_fall,
  output logic             cfg_dirty
);
  localparam int LO_BITS = RES_W - 8;
  localparam int CFG_LSB = CH_W;

  logic             start_q;
  logic             test_q;
  logic             ctrl_wr;
  logic [CFG_W-1:0] cfg_wr;

  assign ctrl_wr    = bus_wr && (bus_addr == ADDR_CTRL);
  assign cfg_wr     = bus_wdata[CFG_LSB +: CFG_W];
  assign start_rise = ctrl_wr && bus_wdata[7] && !start_q;
  assign start_fall = ctrl_wr && !bus_wdata[7] && start_q;
  assign cfg_dirty  = ctrl_wr && (cfg_wr != cfg) && (cfg_wr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      chan    <= '0;
      cfg     <= '0;
      clk_sel <= '0;
      test_q  <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_CTRL) begin
        start_q <= bus_wdata[7];
        chan    <= bus_wdata[CH_W-1:0];
        cfg     <= cfg_wr;
      end else if (bus_addr == ADDR_CLK) begin
        clk_sel <= bus_wdata[1:0];
        test_q  <= bus_wdata[7];
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_RES_LO: bus_rdata = {result[LO_BITS-1:0], {(8-LO_BITS){1'b0}}};
      ADDR_RES_HI: bus_rdata = result[RES_W-1:LO_BITS];
      ADDR_CTRL:   bus_rdata = {start_q, busy, cfg, chan};
      ADDR_CLK:    bus_rdata = {test_q, 5'b0, clk_sel};
      default:     bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/adc_pinmap.sv
module adc_pinmap #(
  parameter int NPIN  = 8,
  parameter int CFG_W = 3
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [NPIN-1:0]  dig_en
);
  localparam logic [CFG_W-1:0] CFG_ALL = '1;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic analog;
    assign analog    = (cfg == CFG_ALL) || (i < int'(cfg));
    assign dig_en[i] = !analog;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W    = 12,
  parameter int NCH      = 8,
  parameter int DIV_FAST = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_en,
  output logic [$clog2(NCH)-1:0] chan_sel,
  output logic [NCH-1:0]   pin_dig_en
);
  localparam int CH_W  = $clog2(NCH);
  localparam int CFG_W = 3;

  logic             busy, active, done, tick;
  logic             start_rise, start_fall, cfg_dirty;
  logic [RES_W-1:0] result;
  logic [CFG_W-1:0] cfg;
  logic [1:0]       clk_sel;

  adc_regs #(.RES_W(RES_W), .CH_W(CH_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .result(result), .chan(chan_sel), .cfg(cfg), .clk_sel(clk_sel),
    .start_rise(start_rise), .start_fall(start_fall), .cfg_dirty(cfg_dirty)
  );

  adc_clkdiv #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk(clk), .rst_n(rst_n), .active(active), .sel(clk_sel), .tick(tick)
  );

  adc_sar_fsm #(.RES_W(RES_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .start_fall(start_fall),
    .cfg_dirty(cfg_dirty), .tick(tick), .cmp_in(cmp_in), .busy(busy),
    .active(active), .sample_en(sample_en), .done(done),
    .dac_code(dac_code), .result(result)
  );

  adc_pinmap #(.NPIN(NCH), .CFG_W(CFG_W)) u_pins (
    .cfg(cfg), .dig_en(pin_dig_en)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 12,
  parameter int NCH   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_rise,
  input logic             cfg_dirty,
  input logic             busy,
  input logic             sample_en,
  input logic             tick,
  input logic             done,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic [2:0]       cfg,
  input logic [NCH-1:0]   pin_dig_en
);
  p_rise_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> busy);

  p_cfg_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dirty |=> busy);

  p_sample_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));

  p_sample_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (dac_code == '0));

  p_tick_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);

  p_digital_default_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 3'd0) |-> (&pin_dig_en));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .cfg_dirty(cfg_dirty),
  .busy(busy), .sample_en(sample_en), .tick(tick), .done(done),
  .dac_code(dac_code), .result(result), .cfg(cfg), .pin_dig_en(pin_dig_en)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic        sample_en;
  logic [2:0]  chan_sel;
  logic [7:0]  pin_dig_en;
  logic [11:0] ain = 12'h000;

  int checks = 0;
  int errors = 0;
  logic [2:0] cur_cfg = 3'd0;
  logic [2:0] cur_chan = 3'd0;

  always #2.5 clk = ~clk;

  assign cmp_in = (ain >= dac_code);

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .dac_code(dac_code), .sample_en(sample_en), .chan_sel(chan_sel),
    .pin_dig_en(pin_dig_en)
  );

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : 32;
  endfunction

  function automatic logic [7:0] dig_of(input logic [2:0] c);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = !((c == 3'd7) || (i < int'(c)));
    return m;
  endfunction

  function automatic logic [7:0] ctrl_byte(input logic st);
    return {st, 1'b0, cur_cfg, cur_chan};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // waits for the flag to drop after a falling start write; returns cycles
  task automatic wait_idle(output int n);
    n = 0;
    bus_addr = 8'h26;
    forever begin
      @(negedge clk);
      n++;
      if (!bus_rdata[6] || n > 5000) break;
    end
  endtask

  task automatic convert(input logic [1:0] sel, input logic tbit, input logic [11:0] val);
    logic [7:0] d;
    int n;
    wr(8'h27, {tbit, 5'b0, sel});
    ain = val;
    wr(8'h26, ctrl_byte(1'b1));
    rd(8'h26, d);
    chk("R4 flag on rise", d[6], 1'b1);
    repeat (3) @(negedge clk);
    chk("R4 no sample while start high", sample_en, 1'b0);
    wr(8'h26, ctrl_byte(1'b0));
    chk("R5 sample phase", sample_en, 1'b1);
    wait_idle(n);
    chk("R5 R8 R9 conversion cycles", n, 13 * div_of(sel));
    rd(8'h25, d);
    chk("R6 R7 high byte", d, val[11:4]);
    rd(8'h24, d);
    chk("R6 R7 low byte", d, {val[3:0], 4'h0});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h24, d); chk("R1 res lo", d, 8'h00);
    rd(8'h25, d); chk("R1 res hi", d, 8'h00);
    rd(8'h26, d); chk("R1 ctrl", d, 8'h00);
    rd(8'h27, d); chk("R1 clk", d, 8'h00);
    chk("R1 sample", sample_en, 1'b0);
    chk("R1 dac", dac_code, 12'h000);
    chk("R1 pins", pin_dig_en, 8'hFF);

    // R2 clock register readback
    wr(8'h27, 8'hFF);
    rd(8'h27, d); chk("R2 clk readback", d, 8'h83);

    // R12 R13 R11 pin field sweep
    for (int c = 1; c < 8; c++) begin
      cur_cfg = 3'(c); cur_chan = 3'(7 - c);
      wr(8'h26, ctrl_byte(1'b0));
      chk("R12 pin enables", pin_dig_en, dig_of(cur_cfg));
      chk("R13 chan_sel", chan_sel, cur_chan);
      rd(8'h26, d);
      chk("R2 R11 ctrl readback flag set", d, {2'b01, cur_cfg, cur_chan});
    end
    convert(2'd0, 1'b0, 12'h5A3);
    rd(8'h26, d); chk("R11 flag cleared by pulse", d[6], 1'b0);
    cur_cfg = 3'd0;
    wr(8'h26, ctrl_byte(1'b0));
    rd(8'h26, d); chk("R11 zero field leaves flag", d[6], 1'b0);
    chk("R12 all digital", pin_dig_en, 8'hFF);

    // R3 result registers read-only
    wr(8'h24, 8'hFF); wr(8'h25, 8'h00);
    rd(8'h25, d); chk("R3 hi unchanged", d, 8'h5A);
    rd(8'h24, d); chk("R3 lo unchanged", d, 8'h30);

    // R6 directed corners
    convert(2'd1, 1'b0, 12'h000);
    convert(2'd1, 1'b0, 12'hFFF);
    convert(2'd2, 1'b0, 12'h800);
    convert(2'd3, 1'b0, 12'h7FF);
    // R9 test bit
    convert(2'd1, 1'b1, 12'h123);

    // R10 abort
    wr(8'h27, 8'h01);
    ain = 12'hABC;
    wr(8'h26, ctrl_byte(1'b1));
    wr(8'h26, ctrl_byte(1'b0));
    repeat (30) @(negedge clk);
    ain = 12'h456;
    wr(8'h26, ctrl_byte(1'b1));
    rd(8'h26, d); chk("R10 flag held on abort", d[6], 1'b1);
    chk("R10 sampling stopped", sample_en, 1'b0);
    repeat (120) @(negedge clk);
    rd(8'h26, d); chk("R10 still busy", d[6], 1'b1);
    rd(8'h25, d); chk("R10 result kept", d, 8'h12);
    wr(8'h26, ctrl_byte(1'b0));
    wait_idle(n);
    chk("R10 fresh conversion cycles", n, 13 * 8);
    rd(8'h25, d); chk("R10 new hi", d, 8'h45);

    // random conversions
    for (int k = 0; k < 24; k++) begin
      convert(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 12'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule